// File: doc/BRIEF.md
# Extended float to signed integer converter

This block turns an 80-bit extended-precision floating-point operand into a two's-complement integer whose width (16, 32 or 64 bits) is set by the parameter `INT_W`. Each operand arrives with its own control bits: a 2-bit rounding mode, a chop request that forces truncation toward zero, and mask bits for the invalid and precision exceptions. The result comes back with status bits:
- invalid
- precision
- round-up (C1)
- error summary
- busy
- a request to force the stack-top field to 7

The result tells the consumer whether the integer should be written at all.

Operands enter and results leave through valid/ready streams. A single output register sits between them. `in_ready` is high when that register is empty or is being drained in the same cycle. An operand accepted on a clock edge is visible at the output after that edge. While `out_valid` is high and `out_ready` is low, the output and all status bits hold, and no new operand is taken.

Several outcomes follow the behaviour of real hardware rather than plain arithmetic:
- a negative value that rounds to exactly the minimum integer;
- a narrow window of values just below the minimum;
- the 16-bit chop variant, which checks range as if it were 32 bits wide and uses 0 as its indefinite value.

Top module: `xf2int_cvt`

## Requirements
- R1: One output register: `in_ready = !out_valid || out_ready`. An accepted operand appears with `out_valid` high after the accepting edge. Outputs stay stable while stalled. After reset, `out_valid` is low.
- R2: The operand is bit 79 sign, bits 78:64 biased exponent (bias 16383), and bits 63:0 mantissa with bit 63 as the explicit integer bit. The rounding mode codes are 00 nearest-even, 01 toward minus infinity, 10 toward plus infinity and 11 toward zero. The magnitude is the mantissa shifted right by 63 minus the unbiased exponent, then rounded and negated for a negative sign.
- R3: Any discarded nonzero bit sets precision. C1 is set exactly when the magnitude was incremented by rounding. A nearest-mode tie goes to the even magnitude.
- R4: A normal value with a negative unbiased exponent gives 0 or ±1 by mode and sign. It always sets precision, and sets C1 when the result is ±1.
- R5: When rounding carries the magnitude up to 2^(INT_W−1), a negative input gives the minimum integer, with precision and C1 set. A positive input is invalid.
- R6: On invalid with the mask set, the indefinite value is written (the minimum integer, but 0 in the 16-bit chop variant). With the mask clear, nothing is written: `out_wr` is 0, `out_int` is 0, and error summary, busy and stack-top override (value 7) are set.
- R7: An unmasked precision exception sets error summary and busy, and the result is still written.
- R8: A negative input with unbiased exponent INT_W−1 gives the minimum integer under either condition below. Precision is set if any of the low 65−INT_W mantissa bits is set. Any other value with that exponent is invalid.
  - For INT_W < 64, when not rounding toward minus infinity or when chopping: mantissa < (2^63 | 2^(65−INT_W)).
  - Otherwise: mantissa == 2^63.
- R9: With chop high, the rounding mode is ignored. The magnitude is truncated toward zero, C1 stays 0, and the overflow-after-rounding check does not apply.
- R10: In the 16-bit chop variant, the ordinary range extends to an unbiased exponent of 30, and the low 16 bits of the signed result are kept. A negative input with exponent 31 and mantissa below 0x8000100000000000 gives 0, with the R8 precision rule.
- R11: Zero gives 0 with no flags. A denormal (exponent field 0, mantissa nonzero) gives 0 with precision set. Infinities, NaNs and unnormals (integer bit clear, exponent field not 0) are invalid.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand offered |
| in_ready | output | 1 | Operand accepted when high with in_valid |
| in_value | input | 80 | Extended-precision operand |
| in_rmode | input | 2 | Rounding mode |
| in_chop | input | 1 | Force truncation variant |
| in_inv_mask | input | 1 | Invalid exception masked |
| in_prec_mask | input | 1 | Precision exception masked |
| out_valid | output | 1 | Result present |
| out_ready | input | 1 | Consumer takes result |
| out_int | output | INT_W | Integer result |
| out_wr | output | 1 | Result is to be stored |
| out_inv | output | 1 | Invalid flag |
| out_prec | output | 1 | Precision flag |
| out_c1 | output | 1 | Magnitude rounded up |
| out_err | output | 1 | Error summary |
| out_busy | output | 1 | Busy |
| out_top_set | output | 1 | Stack-top field override requested |
| out_top | output | 3 | Stack-top value to force |

## Verification
The bound checker watches every cycle for the following:
- stalled outputs hold steady and a stall blocks intake;
- a suppressed write always comes with invalid, error summary and a stack-top value of 7;
- C1 never appears without precision or alongside invalid;
- error summary always has a cause and always matches busy.

Only the bench scenarios can show that the numeric results are correct:
- tie-to-even behaviour;
- the choices between 0 and ±1 for tiny values;
- the boundary at the minimum integer, with its window and mode dependence;
- the peculiar 16-bit chop range.

// File: rtl/xf2i_pkg.sv
package xf2i_pkg;
  typedef enum logic [1:0] {
    RM_NEAR = 2'b00,
    RM_DOWN = 2'b01,
    RM_UP   = 2'b10,
    RM_ZERO = 2'b11
  } rmode_e;

  typedef enum logic [1:0] {
    CL_ZERO   = 2'b00,
    CL_DENORM = 2'b01,
    CL_NORMAL = 2'b10,
    CL_BAD    = 2'b11
  } fclass_e;

  localparam int EXP_BIAS = 16383;
  localparam int EXP_W    = 17;
endpackage

// File: rtl/xf2i_unpack.sv
module xf2i_unpack
  import xf2i_pkg::*;
(
  input  logic [79:0]              val,
  output logic                     sign,
  output fclass_e                  cls,
  output logic signed [EXP_W-1:0]  exp_unb,
  output logic [63:0]              mant
);
  logic [14:0] ef;

  always_comb begin
    sign    = val[79];
    ef      = val[78:64];
    mant    = val[63:0];
    exp_unb = $signed({2'b00, ef}) - 17'sd16383;
    if (ef == 15'd0)
      cls = (mant == 64'd0) ? CL_ZERO : CL_DENORM;
    else if (ef == 15'h7FFF || !mant[63])
      cls = CL_BAD;
    else
      cls = CL_NORMAL;
  end
endmodule

// File: rtl/xf2i_round.sv
module xf2i_round
  import xf2i_pkg::*;
(
  input  logic                     sign,
  input  logic signed [EXP_W-1:0]  exp_unb,
  input  logic [63:0]              mant,
  input  rmode_e                   rm,
  input  logic                     chop,
  output logic [63:0]              mag,
  output logic                     inexact,
  output logic                     incr
);
  logic [127:0] wide;
  logic [6:0]   sh;
  logic         far;
  logic [63:0]  ipart;
  logic         guard, sticky, up_r;

  always_comb begin
    far = (exp_unb < -17'sd1);
    if (exp_unb > 17'sd63)
      sh = 7'd0;
    else if (far)
      sh = 7'd64;
    else
      sh = 7'(17'sd63 - exp_unb);
    wide   = {mant, 64'd0} >> sh;
    ipart  = far ? 64'd0 : wide[127:64];
    guard  = far ? 1'b0 : wide[63];
    sticky = far ? 1'b1 : (|wide[62:0]);
    inexact = guard | sticky;
    unique case (rm)
      RM_NEAR: up_r = guard & (sticky | ipart[0]);
      RM_DOWN: up_r = sign & inexact;
      RM_UP:   up_r = !sign & inexact;
      default: up_r = 1'b0;
    endcase
    incr = !chop & up_r;
    mag  = ipart + {63'd0, incr};
  end
endmodule

// File: rtl/xf2i_select.sv
module xf2i_select
  import xf2i_pkg::*;
#(
  parameter int N = 16
) (
  input  logic                     sign,
  input  fclass_e                  cls,
  input  logic signed [EXP_W-1:0]  exp_unb,
  input  logic [63:0]              mant,
  input  logic [63:0]              mag,
  input  logic                     inexact,
  input  logic                     incr,
  input  rmode_e                   rm,
  input  logic                     chop,
  input  logic                     im,
  input  logic                     pm,
  output logic [N-1:0]             res,
  output logic                     wr,
  output logic                     inv,
  output logic                     prec,
  output logic                     c1,
  output logic                     err,
  output logic                     top_set
);
  localparam logic signed [EXP_W-1:0] LIM_STD = EXP_W'(N - 2);
  localparam logic signed [EXP_W-1:0] LIM_W16 = 17'sd30;
  localparam logic signed [EXP_W-1:0] E_TOP   = EXP_W'(N - 1);
  localparam logic signed [EXP_W-1:0] E_31    = 17'sd31;
  localparam int          LOW_W    = 65 - N;
  localparam logic [63:0] BIT63    = 64'h8000_0000_0000_0000;
  localparam logic [63:0] NEAR_LIM = BIT63 | (64'd1 << LOW_W);
  localparam logic [63:0] LOW_MASK = (64'd1 << LOW_W) - 64'd1;
  localparam logic [63:0] WIN16    = 64'h8000_1000_0000_0000;
  localparam logic [N-1:0] MINV    = {1'b1, {(N-1){1'b0}}};

  logic          odd16;
  logic [N-1:0]  indef;
  logic signed [EXP_W-1:0] lim;
  logic          ovf, min_cond, bad;

  generate
    if (N == 16) begin : g_w16
      assign odd16 = chop;
      assign indef = chop ? '0 : MINV;
    end else begin : g_wide
      assign odd16 = 1'b0;
      assign indef = MINV;
    end
  endgenerate

  always_comb begin
    lim = odd16 ? LIM_W16 : LIM_STD;
    ovf = !chop && (|mag[63:N-1]);
    if (N < 64 && (chop || rm != RM_DOWN))
      min_cond = mant < NEAR_LIM;
    else
      min_cond = mant == BIT63;
    res  = '0;
    wr   = 1'b1;
    prec = 1'b0;
    c1   = 1'b0;
    bad  = 1'b0;
    unique case (cls)
      CL_ZERO:   res = '0;
      CL_DENORM: prec = 1'b1;
      CL_BAD:    bad = 1'b1;
      default: begin
        if (exp_unb <= lim) begin
          if (ovf) begin
            if (sign) begin
              res  = MINV;
              prec = inexact;
              c1   = incr;
            end else begin
              bad = 1'b1;
            end
          end else begin
            res  = sign ? ({N{1'b0}} - mag[N-1:0]) : mag[N-1:0];
            prec = inexact;
            c1   = incr;
          end
        end else if (sign && exp_unb == E_TOP && min_cond) begin
          res  = MINV;
          prec = |(mant & LOW_MASK);
        end else if (odd16 && sign && exp_unb == E_31 && mant < WIN16) begin
          res  = '0;
          prec = |(mant & LOW_MASK);
        end else begin
          bad = 1'b1;
        end
      end
    endcase
    inv = bad;
    if (bad) begin
      prec = 1'b0;
      c1   = 1'b0;
      if (im) begin
        res = indef;
      end else begin
        res = '0;
        wr  = 1'b0;
      end
    end
    top_set = inv & !im;
    err     = top_set | (prec & !pm);
  end
endmodule

// File: rtl/xf2int_cvt.sv
module xf2int_cvt
  import xf2i_pkg::*;
#(
  parameter int INT_W = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [79:0]       in_value,
  input  logic [1:0]        in_rmode,
  input  logic              in_chop,
  input  logic              in_inv_mask,
  input  logic              in_prec_mask,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [INT_W-1:0]  out_int,
  output logic              out_wr,
  output logic              out_inv,
  output logic              out_prec,
  output logic              out_c1,
  output logic              out_err,
  output logic              out_busy,
  output logic              out_top_set,
  output logic [2:0]        out_top
);
  logic                    sgn;
  fclass_e                 cls;
  logic signed [EXP_W-1:0] eu;
  logic [63:0]             mant, mag;
  logic                    inexact, incr;
  rmode_e                  rm;
  logic [INT_W-1:0]        n_res;
  logic                    n_wr, n_inv, n_prec, n_c1, n_err, n_top;
  logic                    accept;

  assign rm = rmode_e'(in_rmode);

  xf2i_unpack u_unpack (
    .val(in_value), .sign(sgn), .cls(cls), .exp_unb(eu), .mant(mant)
  );

  xf2i_round u_round (
    .sign(sgn), .exp_unb(eu), .mant(mant), .rm(rm), .chop(in_chop),
    .mag(mag), .inexact(inexact), .incr(incr)
  );

  xf2i_select #(.N(INT_W)) u_select (
    .sign(sgn), .cls(cls), .exp_unb(eu), .mant(mant), .mag(mag),
    .inexact(inexact), .incr(incr), .rm(rm), .chop(in_chop),
    .im(in_inv_mask), .pm(in_prec_mask),
    .res(n_res), .wr(n_wr), .inv(n_inv), .prec(n_prec), .c1(n_c1),
    .err(n_err), .top_set(n_top)
  );

  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_valid   <= 1'b0;
      out_int     <= '0;
      out_wr      <= 1'b0;
      out_inv     <= 1'b0;
      out_prec    <= 1'b0;
      out_c1      <= 1'b0;
      out_err     <= 1'b0;
      out_busy    <= 1'b0;
      out_top_set <= 1'b0;
      out_top     <= 3'd0;
    end else if (accept) begin
      out_valid   <= 1'b1;
      out_int     <= n_res;
      out_wr      <= n_wr;
      out_inv     <= n_inv;
      out_prec    <= n_prec;
      out_c1      <= n_c1;
      out_err     <= n_err;
      out_busy    <= n_err;
      out_top_set <= n_top;
      out_top     <= n_top ? 3'd7 : 3'd0;
    end else if (out_ready) begin
      out_valid   <= 1'b0;
    end
  end
endmodule

// File: rtl/xf2int_cvt_chk.sv
module xf2int_cvt_chk #(
  parameter int INT_W = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              in_valid,
  input logic              in_ready,
  input logic              out_valid,
  input logic              out_ready,
  input logic [INT_W-1:0]  out_int,
  input logic              out_wr,
  input logic              out_inv,
  input logic              out_prec,
  input logic              out_c1,
  input logic              out_err,
  input logic              out_busy,
  input logic              out_top_set,
  input logic [2:0]        out_top
);
  // R1: a stalled result holds and blocks intake
  p_hold_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_int) && $stable(out_inv)
      && $stable(out_prec) && $stable(out_c1) && $stable(out_wr));
  p_stall_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |-> !in_ready);
  // R1: drained with nothing offered empties the register
  p_drain_r1: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_ready && !in_valid |=> !out_valid);
  // R6: suppressed write only on unmasked invalid
  p_nowr_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_wr |-> out_inv && out_top_set && out_top == 3'd7
      && out_err && out_int == '0);
  // R3: C1 implies an inexact, valid conversion
  p_c1_r3: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_c1 |-> out_prec && !out_inv);
  // R7: error summary has a cause and tracks busy
  p_err_r7: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && out_err |-> out_busy && (out_inv || out_prec));
endmodule

bind xf2int_cvt xf2int_cvt_chk #(.INT_W(INT_W)) chk_i (
  .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_ready(out_ready), .out_int(out_int),
  .out_wr(out_wr), .out_inv(out_inv), .out_prec(out_prec), .out_c1(out_c1),
  .out_err(out_err), .out_busy(out_busy), .out_top_set(out_top_set),
  .out_top(out_top)
);

// File: tb/xf2int_cvt_tb_top.sv
module xf2int_cvt_tb_top;
  localparam int W = 16;

  typedef struct packed {
    logic [79:0] v;
    logic [1:0]  rm;
    logic        ch, im, pm;
    logic [15:0] q;
    logic        wr, inv, prec, c1;
    logic [7:0]  req;
  } vec_t;

  function automatic logic [79:0] mk(input logic s, input int e, input logic [63:0] m);
    return {s, 15'(e + 16383), m};
  endfunction

  localparam logic [63:0] M10 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] M25 = 64'hA000_0000_0000_0000;
  localparam logic [63:0] M35 = 64'hE000_0000_0000_0000;
  localparam logic [63:0] MC0 = 64'hC000_0000_0000_0000;
  localparam logic [63:0] MFF = 64'hFFFF_0000_0000_0000;
  localparam logic [63:0] MH5 = 64'h8000_8000_0000_0000;
  localparam logic [63:0] MW  = 64'h8000_0800_0000_0000;

  localparam int NV = 29;
  localparam vec_t VT [NV] = '{
    '{mk(0,0,M10),  2'd0,1'b0,1'b1,1'b1,16'h0001,1'b1,1'b0,1'b0,1'b0,8'd2},  // R2
    '{mk(0,1,M25),  2'd0,1'b0,1'b1,1'b1,16'h0002,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3 tie even
    '{mk(0,1,M35),  2'd0,1'b0,1'b1,1'b1,16'h0004,1'b1,1'b0,1'b1,1'b1,8'd3},  // R3 tie up
    '{mk(1,1,M25),  2'd0,1'b0,1'b1,1'b1,16'hFFFE,1'b1,1'b0,1'b1,1'b0,8'd3},  // R3
    '{mk(0,1,M25),  2'd2,1'b0,1'b1,1'b1,16'h0003,1'b1,1'b0,1'b1,1'b1,8'd2},  // R2 up
    '{mk(1,1,M25),  2'd2,1'b0,1'b1,1'b1,16'hFFFE,1'b1,1'b0,1'b1,1'b0,8'd2},  // R2 up neg
    '{mk(1,1,M25),  2'd1,1'b0,1'b1,1'b1,16'hFFFD,1'b1,1'b0,1'b1,1'b1,8'd2},  // R2 down
    '{mk(0,1,M25),  2'd3,1'b0,1'b1,1'b1,16'h0002,1'b1,1'b0,1'b1,1'b0,8'd2},  // R2 zero
    '{mk(0,1,M25),  2'd2,1'b1,1'b1,1'b1,16'h0002,1'b1,1'b0,1'b1,1'b0,8'd9},  // R9
    '{mk(0,-1,MC0), 2'd0,1'b0,1'b1,1'b1,16'h0001,1'b1,1'b0,1'b1,1'b1,8'd4},  // R4
    '{mk(0,-1,M10), 2'd0,1'b0,1'b1,1'b1,16'h0000,1'b1,1'b0,1'b1,1'b0,8'd4},  // R4
    '{mk(1,-2,M10), 2'd1,1'b0,1'b1,1'b1,16'hFFFF,1'b1,1'b0,1'b1,1'b1,8'd4},  // R4
    '{mk(0,14,MFF), 2'd0,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b1,1'b0,1'b0,8'd5},  // R5 pos
    '{mk(1,14,MFF), 2'd0,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b0,1'b1,1'b1,8'd5},  // R5 neg
    '{mk(0,14,MFF), 2'd0,1'b0,1'b0,1'b1,16'h0000,1'b0,1'b1,1'b0,1'b0,8'd6},  // R6
    '{mk(1,15,M10), 2'd0,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b0,1'b0,1'b0,8'd8},  // R8
    '{mk(1,15,MH5), 2'd0,1'b0,1'b1,1'b0,16'h8000,1'b1,1'b0,1'b1,1'b0,8'd7},  // R7
    '{mk(1,15,MH5), 2'd1,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b1,1'b0,1'b0,8'd8},  // R8 down
    '{mk(0,15,64'h9C40_0000_0000_0000), 2'd0,1'b1,1'b1,1'b1,16'h9C40,1'b1,1'b0,1'b0,1'b0,8'd10}, // R10
    '{mk(1,16,64'h88B8_0000_0000_0000), 2'd0,1'b1,1'b1,1'b1,16'hEE90,1'b1,1'b0,1'b0,1'b0,8'd10}, // R10
    '{mk(1,31,MW),  2'd0,1'b1,1'b1,1'b1,16'h0000,1'b1,1'b0,1'b1,1'b0,8'd10}, // R10 window
    '{mk(0,31,M10), 2'd0,1'b1,1'b1,1'b1,16'h0000,1'b1,1'b1,1'b0,1'b0,8'd10}, // R10 indef 0
    '{mk(1,15,MH5), 2'd0,1'b1,1'b1,1'b1,16'h8000,1'b1,1'b0,1'b1,1'b0,8'd9},  // R9
    '{{1'b0,15'h7FFF,M10}, 2'd0,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b1,1'b0,1'b0,8'd11}, // R11 inf
    '{80'd0,        2'd0,1'b0,1'b1,1'b1,16'h0000,1'b1,1'b0,1'b0,1'b0,8'd11}, // R11 zero
    '{{1'b0,15'h0,64'd1}, 2'd2,1'b0,1'b1,1'b1,16'h0000,1'b1,1'b0,1'b1,1'b0,8'd11}, // R11 denorm
    '{{1'b0,15'h4000,64'h4000_0000_0000_0000}, 2'd0,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b1,1'b0,1'b0,8'd11}, // R11 unnormal
    '{mk(1,31,MW),  2'd0,1'b0,1'b1,1'b1,16'h8000,1'b1,1'b1,1'b0,1'b0,8'd10}, // R10 only when chopping
    '{mk(1,31,MW),  2'd0,1'b1,1'b1,1'b0,16'h0000,1'b1,1'b0,1'b1,1'b0,8'd7}   // R7 window unmasked
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1;
  logic [79:0] in_value = '0;
  logic [1:0] in_rmode = '0;
  logic in_chop = 1'b0, in_inv_mask = 1'b1, in_prec_mask = 1'b1;
  logic in_ready, out_valid, out_wr, out_inv, out_prec, out_c1, out_err, out_busy, out_top_set;
  logic [W-1:0] out_int;
  logic [2:0] out_top;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  xf2int_cvt #(.INT_W(W)) dut_i (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_value(in_value), .in_rmode(in_rmode), .in_chop(in_chop),
    .in_inv_mask(in_inv_mask), .in_prec_mask(in_prec_mask),
    .out_valid(out_valid), .out_ready(out_ready), .out_int(out_int),
    .out_wr(out_wr), .out_inv(out_inv), .out_prec(out_prec), .out_c1(out_c1),
    .out_err(out_err), .out_busy(out_busy), .out_top_set(out_top_set),
    .out_top(out_top)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_vec(input vec_t t, input int idx);
    logic e_err, e_top;
    e_top = t.inv & !t.im;
    e_err = e_top | (t.prec & !t.pm);
    check($sformatf("R%0d vec%0d fields {valid,int,wr,inv,prec,c1,err,busy,topset,top}", t.req, idx),
          {7'd0, out_valid, out_int, out_wr, out_inv, out_prec, out_c1, out_err, out_busy, out_top_set, out_top},
          {7'd0, 1'b1, t.q, t.wr, t.inv, t.prec, t.c1, e_err, e_err, e_top, e_top ? 3'd7 : 3'd0});
  endtask

  task automatic summary;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
  endtask

  initial begin
    #(20 * 20000);
    if (!done) begin
      errors++;
      $display("FAIL R1 watchdog actual=hung expected=complete");
      summary();
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check("R1 reset out_valid", {31'd0, out_valid}, 32'd0);
    check("R1 reset in_ready", {31'd0, in_ready}, 32'd1);

    for (int i = 0; i < NV; i++) begin
      in_value = VT[i].v; in_rmode = VT[i].rm; in_chop = VT[i].ch;
      in_inv_mask = VT[i].im; in_prec_mask = VT[i].pm;
      in_valid = 1'b1;
      @(negedge clk);
      in_valid = 1'b0;
      check_vec(VT[i], i);
      @(negedge clk);
    end

    // R1 back-pressure: hold result A while B waits
    out_ready = 1'b0;
    in_value = mk(0, 0, M10); in_rmode = 2'd0; in_chop = 1'b0;
    in_inv_mask = 1'b1; in_prec_mask = 1'b1;
    in_valid = 1'b1;
    @(negedge clk);
    in_value = mk(0, 1, M35);
    for (int k = 0; k < 3; k++) begin
      check("R1 stall in_ready", {31'd0, in_ready}, 32'd0);
      check("R1 stall out_int", {16'd0, out_int}, 32'h0001);
      @(negedge clk);
    end
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    check("R1 released next out_int", {16'd0, out_int}, 32'h0004);
    check("R1 released next valid", {31'd0, out_valid}, 32'd1);
    @(negedge clk);
    check("R1 drained valid", {31'd0, out_valid}, 32'd0);

    done = 1'b1;
    summary();
    $finish;
  end
endmodule